// File: doc/BRIEF.md
# Fuse Programming Sequencer

This block drives a one-time-programmable fuse array that sits behind a 16-byte shadow configuration RAM. Software fills the shadow RAM through a byte-wide register port and then sets a start bit. The sequencer walks every shadow bit in ascending bit order, byte 0 bit 0 first. For each bit that holds one, it applies a burn pulse of fixed length to the matching fuse. When the walk ends it reports the outcome in a status register. The start bit clears itself when the run ends. The fuse array is modelled as sticky bits that can only change from 0 to 1.

Before a run begins, the block checks three conditions: the programming-voltage-present input, the test-mode code input, and a bias field held in the shadow RAM. A run that fails the check never starts. Software can read the fuse contents back through a separate address window to verify them. To retry after a failed verification, software writes zero to the shadow bits that are already fused. Only the bits still at one are burned again.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset the status register (0x77), the control register (0x76), every shadow byte (0x00-0x0F, including the high-read-current control at 0x0F bit 7) and every fuse byte (0x10-0x1F) read 0x00, and `busy` is low.
- R2: While the sequencer is idle, a write to address 0x00-0x0F stores the byte in the shadow RAM, and a read of that address returns it.
- R3: Writing 1 to bit 0 of address 0x76 starts a run when all three checks pass. While the run is active, that bit reads 1 and `busy` is high. Both return to 0 by themselves when the run ends.
- R4: A run burns exactly the shadow bits that are 1. Fuse byte n reads back at address 0x10+n as the bitwise OR of its old value and the shadow byte n that was burned.
- R5: Each burn holds `burn_pulse` high for PULSE_CYCLES consecutive cycles. Bits are burned one at a time in ascending order of index (byte*8 + bit), and `burn_bit` shows that index.
- R6: The status register 0x77 has OK at bit 0 and ERR at bit 7. A completed run reads 0x01. OK and ERR are never both 1.
- R7: If `test_code` is not 0x00 when start is written, the run is refused: status reads 0x80, nothing is burned, and `busy` stays low.
- R8: If the bias field (shadow byte 0x04, bits 3:0) is not zero when start is written, the run is refused and status reads 0x80.
- R9: If `vprog_ok` is low when start is written (with `test_code` at zero and the bias field at zero), the run is refused and status reads 0x00.
- R10: If `vprog_ok` drops while `burn_pulse` is high, the run aborts on the next clock edge. Status reads 0x80, `busy` falls, and the fuse being burned is not set.
- R11: OK and ERR both clear when a new run starts, so status reads 0x00 while the run is busy.
- R12: While `busy` is high, writes to the shadow RAM and to the start bit have no effect.
- R13: Once a fuse bit is 1, it stays 1 until reset. A run started with an all-zero shadow RAM completes with status 0x01 and leaves every fuse unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the fuse model |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| vprog_ok | input | 1 | Programming voltage is present |
| test_code | input | 8 | Test-mode code; must be zero to program |
| busy | output | 1 | A run is in progress |
| burn_pulse | output | 1 | A burn pulse is being applied |
| burn_bit | output | 7 | Index of the bit being scanned or burned |

## Verification
The bench builds the block with PULSE_CYCLES set to 3 and the default 16 bytes. With these values a full 128-bit scan plus its pulses takes under two hundred cycles, so a single run can cover a burn at any byte, including retries on a fuse byte that is already partly burned. A short pulse also lets the bench drop the programming voltage within the first cycle of a pulse. It can then count exact pulse lengths and record the ascending burn order across bytes.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_BURN = 2'd2
    } seq_state_e;

    localparam logic [7:0] FUSE_BASE  = 8'h10;
    localparam logic [7:0] CTRL_ADDR  = 8'h76;
    localparam logic [7:0] STAT_ADDR  = 8'h77;
    localparam int         BIAS_BYTE  = 4;
    localparam int         BIAS_WIDTH = 4;
endpackage

// File: rtl/fuse_shadow_ram.sv
module fuse_shadow_ram #(
    parameter int NBYTES = 16,
    localparam int SW    = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_sel,
    input  logic [7:0]            wdata,
    output logic [NBYTES*8-1:0]   shadow_bits
);
    logic [NBYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_sel] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign shadow_bits = mem_q;
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model #(
    parameter int NBITS = 128,
    localparam int IW   = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burn_commit,
    input  logic [IW-1:0]    burn_idx,
    output logic [NBITS-1:0] fuse_bits
);
    logic [NBITS-1:0] fuse_d, fuse_q;

    for (genvar b = 0; b < NBITS; b++) begin : g_fuse
        always_comb fuse_d[b] = fuse_q[b] | (burn_commit && (burn_idx == IW'(b)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fuse_q <= '0;
        else        fuse_q <= fuse_d;
    end

    assign fuse_bits = fuse_q;
endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
#(
    parameter int NBITS        = 128,
    parameter int PULSE_CYCLES = 50,
    localparam int IW          = $clog2(NBITS),
    localparam int CW          = $clog2(PULSE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] shadow_bits,
    input  logic             vprog_ok,
    input  logic [7:0]       test_code,
    input  logic             bias_zero,
    output logic             busy,
    output logic             burn_pulse,
    output logic             burn_commit,
    output logic [IW-1:0]    burn_idx,
    output logic             stat_ok,
    output logic             stat_err
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);
    localparam logic [CW-1:0] END_CNT  = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          ok;
        logic          err;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  commit_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.ok  = 1'b0;
                    s_d.err = 1'b0;
                    if ((test_code != 8'h00) || !bias_zero) begin
                        s_d.err = 1'b1;
                    end else if (vprog_ok) begin
                        s_d.st  = ST_SCAN;
                        s_d.idx = '0;
                    end
                end
            end
            ST_SCAN: begin
                if (shadow_bits[s_q.idx]) begin
                    s_d.st  = ST_BURN;
                    s_d.cnt = '0;
                end else if (s_q.idx == LAST_IDX) begin
                    s_d.st = ST_IDLE;
                    s_d.ok = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_BURN: begin
                if (!vprog_ok) begin
                    s_d.st  = ST_IDLE;
                    s_d.err = 1'b1;
                end else if (s_q.cnt == END_CNT) begin
                    commit_d = 1'b1;
                    if (s_q.idx == LAST_IDX) begin
                        s_d.st = ST_IDLE;
                        s_d.ok = 1'b1;
                    end else begin
                        s_d.st  = ST_SCAN;
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, idx: '0, cnt: '0, ok: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign burn_pulse  = (s_q.st == ST_BURN);
    assign burn_commit = commit_d;
    assign burn_idx    = s_q.idx;
    assign stat_ok     = s_q.ok;
    assign stat_err    = s_q.err;
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
    import fuse_seq_pkg::*;
#(
    parameter int NBYTES       = 16,
    parameter int PULSE_CYCLES = 50,
    localparam int NBITS       = NBYTES * 8,
    localparam int IW          = $clog2(NBITS),
    localparam int SW          = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          vprog_ok,
    input  logic [7:0]    test_code,
    output logic          busy,
    output logic          burn_pulse,
    output logic [IW-1:0] burn_bit
);
    logic [NBITS-1:0] shadow_bits;
    logic [NBITS-1:0] fuse_bits;
    logic             burn_commit;
    logic             stat_ok, stat_err;
    logic             in_shadow, in_fuse;
    logic [7:0]       fuse_off;
    logic             shadow_we, start_req, bias_zero;

    assign fuse_off  = reg_addr - FUSE_BASE;
    assign in_shadow = (reg_addr < 8'(NBYTES));
    assign in_fuse   = (fuse_off < 8'(NBYTES));
    assign shadow_we = reg_wr && in_shadow && !busy;
    assign start_req = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[0] && !busy;
    assign bias_zero = (shadow_bits[BIAS_BYTE*8 +: BIAS_WIDTH] == '0);

    fuse_shadow_ram #(.NBYTES(NBYTES)) shadow_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (shadow_we),
        .wr_sel      (reg_addr[SW-1:0]),
        .wdata       (reg_wdata),
        .shadow_bits (shadow_bits)
    );

    fuse_seq_ctrl #(.NBITS(NBITS), .PULSE_CYCLES(PULSE_CYCLES)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_req),
        .shadow_bits (shadow_bits),
        .vprog_ok    (vprog_ok),
        .test_code   (test_code),
        .bias_zero   (bias_zero),
        .busy        (busy),
        .burn_pulse  (burn_pulse),
        .burn_commit (burn_commit),
        .burn_idx    (burn_bit),
        .stat_ok     (stat_ok),
        .stat_err    (stat_err)
    );

    fuse_array_model #(.NBITS(NBITS)) fuse_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .burn_commit (burn_commit),
        .burn_idx    (burn_bit),
        .fuse_bits   (fuse_bits)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (in_shadow)                   reg_rdata = shadow_bits[reg_addr[SW-1:0]*8 +: 8];
        else if (in_fuse)                reg_rdata = fuse_bits[fuse_off[SW-1:0]*8 +: 8];
        else if (reg_addr == CTRL_ADDR)  reg_rdata = {7'b0, busy};
        else if (reg_addr == STAT_ADDR)  reg_rdata = {stat_err, 6'b0, stat_ok};
    end
endmodule

// File: rtl/fuse_burn_seq_chk.sv
module fuse_burn_seq_chk #(
    parameter int NBITS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             burn_pulse,
    input logic             vprog_ok,
    input logic             ok,
    input logic             err,
    input logic [NBITS-1:0] fuse_bits,
    input logic [NBITS-1:0] shadow_bits
);
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && err));

    a_r5_pulse_within_run: assert property (@(posedge clk) disable iff (!rst_n)
        burn_pulse |-> busy);

    a_r10_drop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (burn_pulse && !vprog_ok) |=> (err && !ok && !busy));

    a_r12_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(shadow_bits));

    a_r13_fuse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_bits & $past(fuse_bits)) == $past(fuse_bits)));

    a_r4_fuse_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_bits == $past(fuse_bits)) || $past(burn_pulse)));
endmodule

bind fuse_burn_seq fuse_burn_seq_chk #(.NBITS(NBITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .burn_pulse  (burn_pulse),
    .vprog_ok    (vprog_ok),
    .ok          (stat_ok),
    .err         (stat_err),
    .fuse_bits   (fuse_bits),
    .shadow_bits (shadow_bits)
);

// File: tb/fuse_burn_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_burn_seq_tb_top;
    localparam int PULSE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       vprog_ok = 1'b1;
    logic [7:0] test_code = '0;
    logic       busy, burn_pulse;
    logic [6:0] burn_bit;

    int checks = 0;
    int fails  = 0;
    int pulse_cnt = 0;
    int seq_n = 0;
    logic [6:0] seq_log [64];
    logic prev_p = 1'b0;
    logic [7:0] fmodel [16];

    // {shadow byte index, pattern}
    localparam logic [11:0] VEC [4] = '{
        {4'd0,  8'h81},
        {4'd1,  8'h3C},
        {4'd15, 8'hF0},
        {4'd0,  8'h42}
    };

    always #5 clk = ~clk;

    fuse_burn_seq #(.NBYTES(16), .PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vprog_ok(vprog_ok),
        .test_code(test_code), .busy(busy), .burn_pulse(burn_pulse),
        .burn_bit(burn_bit)
    );

    always @(posedge clk) begin
        if (burn_pulse) pulse_cnt <= pulse_cnt + 1;
        if (burn_pulse && !prev_p) begin
            seq_log[seq_n % 64] <= burn_bit;
            seq_n <= seq_n + 1;
        end
        prev_p <= burn_pulse;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        int n = 0;
        v = 8'h01;
        while (v[0] && n < 3000) begin
            rd(8'h76, v);
            n++;
        end
        chk({req, " run ends"}, 32'(v[0]), 32'd0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int p0, s0;
        for (int i = 0; i < 16; i++) fmodel[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h77, v); chk("R1 status", v, 8'h00);
        rd(8'h76, v); chk("R1 control", v, 8'h00);
        rd(8'h0F, v); chk("R1 high-current bit", v, 8'h00);
        rd(8'h10, v); chk("R1 fuse byte0", v, 8'h00);
        rd(8'h1F, v); chk("R1 fuse byte15", v, 8'h00);
        chk("R1 busy", busy, 1'b0);

        // R2 shadow write/read
        wr(8'h07, 8'h5A);
        rd(8'h07, v); chk("R2 shadow readback", v, 8'h5A);
        wr(8'h07, 8'h00);

        // Vector table: burn, verify, clear shadow (retry style)
        foreach (VEC[k]) begin
            logic [3:0] b;
            logic [7:0] d;
            b = VEC[k][11:8];
            d = VEC[k][7:0];
            wr({4'h0, b}, d);
            p0 = pulse_cnt;
            wr(8'h76, 8'h01);
            rd(8'h76, v); chk("R3 start bit busy", v, 8'h01);
            wait_idle("R3");
            fmodel[b] = fmodel[b] | d;
            rd(8'h77, v); chk("R6 status ok", v, 8'h01);
            rd(8'h10 + {4'h0, b}, v); chk("R4 fuse readback", v, fmodel[b]);
            chk("R5 pulse cycles", pulse_cnt - p0, $countones(d) * PULSE);
            wr({4'h0, b}, 8'h00);
        end

        // R5 ascending order across bytes
        wr(8'h08, 8'h11); wr(8'h09, 8'h01);
        s0 = seq_n;
        wr(8'h76, 8'h01);
        wait_idle("R5");
        chk("R5 burn count", seq_n - s0, 3);
        chk("R5 first bit", seq_log[s0 % 64], 7'd64);
        chk("R5 second bit", seq_log[(s0 + 1) % 64], 7'd68);
        chk("R5 third bit", seq_log[(s0 + 2) % 64], 7'd72);
        fmodel[8] = 8'h11; fmodel[9] = 8'h01;
        wr(8'h08, 8'h00); wr(8'h09, 8'h00);

        // R7 test mode refuses
        test_code = 8'h05;
        wr(8'h0A, 8'h01);
        wr(8'h76, 8'h01);
        rd(8'h76, v); chk("R7 not busy", v, 8'h00);
        rd(8'h77, v); chk("R7 status err", v, 8'h80);
        rd(8'h1A, v); chk("R7 nothing burned", v, 8'h00);
        test_code = 8'h00;

        // R11 flags cleared on new run
        wr(8'h76, 8'h01);
        rd(8'h77, v); chk("R11 status cleared while busy", v, 8'h00);
        wait_idle("R11");
        rd(8'h77, v); chk("R11 status after run", v, 8'h01);
        rd(8'h1A, v); chk("R11 fuse burned", v, 8'h01);
        wr(8'h0A, 8'h00);

        // R8 bias field nonzero refuses
        wr(8'h04, 8'h03);
        wr(8'h76, 8'h01);
        rd(8'h76, v); chk("R8 not busy", v, 8'h00);
        rd(8'h77, v); chk("R8 status err", v, 8'h80);
        wr(8'h04, 8'h00);

        // R9 missing voltage refuses with both flags clear
        vprog_ok = 1'b0;
        wr(8'h0B, 8'h01);
        wr(8'h76, 8'h01);
        rd(8'h76, v); chk("R9 not busy", v, 8'h00);
        rd(8'h77, v); chk("R9 status", v, 8'h00);
        rd(8'h1B, v); chk("R9 nothing burned", v, 8'h00);
        vprog_ok = 1'b1;

        // R10 voltage drop mid-pulse
        wr(8'h76, 8'h01);
        begin
            int n = 0;
            @(negedge clk);
            while (!burn_pulse && n < 500) begin @(negedge clk); n++; end
        end
        vprog_ok = 1'b0;
        repeat (3) @(negedge clk);
        vprog_ok = 1'b1;
        chk("R10 busy low", busy, 1'b0);
        rd(8'h77, v); chk("R10 status err only", v, 8'h80);
        rd(8'h1B, v); chk("R10 bit not fused", v, 8'h00);
        wr(8'h76, 8'h01);
        wait_idle("R10");
        rd(8'h1B, v); chk("R10 retry burns", v, 8'h01);
        wr(8'h0B, 8'h00);

        // R12 writes ignored while busy
        wr(8'h05, 8'hFF);
        p0 = pulse_cnt;
        wr(8'h76, 8'h01);
        wr(8'h06, 8'hAA);
        wr(8'h76, 8'h01);
        wait_idle("R12");
        repeat (3) @(negedge clk);
        chk("R12 busy stays low", busy, 1'b0);
        rd(8'h06, v); chk("R12 shadow write ignored", v, 8'h00);
        rd(8'h16, v); chk("R12 fuse byte6", v, 8'h00);
        chk("R12 single run pulses", pulse_cnt - p0, 8 * PULSE);
        rd(8'h15, v); chk("R12 fuse byte5", v, 8'hFF);
        wr(8'h05, 8'h00);

        // R13 empty shadow run keeps fuses
        p0 = pulse_cnt;
        wr(8'h76, 8'h01);
        wait_idle("R13");
        rd(8'h77, v); chk("R13 status ok", v, 8'h01);
        chk("R13 no pulses", pulse_cnt - p0, 0);
        rd(8'h10, v); chk("R13 fuse byte0 kept", v, fmodel[0]);
        rd(8'h1F, v); chk("R13 fuse byte15 kept", v, fmodel[15]);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule